// File: doc/BRIEF.md
# Ping-Pong Frame DMA Address Generator

This block turns a stream of image elements waiting in a receive FIFO into single write requests toward memory. Each request carries one element and the byte address where it belongs. Frames land in one of two 32-byte-aligned frame buffers, and the buffers alternate from frame to frame. The first buffer is called ping and the second pong. Within a frame, the elements of a line go to consecutive addresses. Each new line starts a programmable byte offset past the start of the line before it.

A producer pulses `frameStart` at the start of each frame and `lineEnd` once the last element of a line has been taken from the FIFO. The FIFO presents its fill level and its head element; the block pops it with `fifoPop`. The write port is a plain request/grant pair. A request is held, with address and data stable, until it is granted. When a grant and fresh FIFO data meet in the same cycle, the next request follows at once with no idle cycle. Clearing `enable` ends the current frame and sends the buffer alternation back to ping.

Top module: `ppdma_addr_gen`

## Requirements
- R1: After reset, `reqValid` and `fifoPop` are 0.
- R2: Buffer base inputs carry address bits 31:5 only. The first element of a frame is written at the selected base with its low five address bits zero.
- R3: While enabled, the first frame after enable uses the ping base. Each later `frameStart` alternates pong, ping, pong, and so on.
- R4: Within one line, successive elements are written at addresses that increase by `ELEM_BYTES` (default 4).
- R5: After `lineEnd`, the next element is written at the start address of the line just finished plus `lineOffset` (in bytes).
- R6: While `reqValid` is 1 and `reqGrant` is 0, `reqValid`, `reqAddr` and `reqData` keep their values, and no element is popped.
- R7: With the FIFO holding data and `reqGrant` held at 1, grants happen on consecutive cycles with no idle cycle. Element data is issued in FIFO order.
- R8: No element is popped and no request is raised while the FIFO level is 0, while no frame is active, or while `enable` is 0.
- R9: Clearing and then setting `enable` restarts the alternation, so the next frame uses the ping base whatever the previous parity was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; 0 ends the frame and resets alternation |
| pingBase | input | ADDR_W-ALIGN_W | Ping buffer base, address bits 31:5 |
| pongBase | input | ADDR_W-ALIGN_W | Pong buffer base, address bits 31:5 |
| lineOffset | input | OFS_W | Byte distance between consecutive line starts |
| frameStart | input | 1 | One-cycle pulse at frame start |
| lineEnd | input | 1 | One-cycle pulse after the last element of a line is taken |
| fifoLevel | input | LVL_W | Number of elements held in the FIFO |
| fifoData | input | DATA_W | FIFO head element |
| fifoPop | output | 1 | Takes the head element this cycle |
| reqValid | output | 1 | Write request pending |
| reqGrant | input | 1 | Request accepted this cycle |
| reqAddr | output | ADDR_W | Byte address of the pending write |
| reqData | output | DATA_W | Data of the pending write |

## Verification
A wrong buffer-select bit shows up as the wrong base on the first request of the next frame, one cycle after the FIFO first holds data. A wrong line-start register or next-address register gives a wrong `reqAddr` on the very next loaded element, and that error carries through the rest of the line. A wrong request-valid state shows at once as a lost or duplicated element, or as an idle gap in a granted stream. The FIFO pop count and the data sequence expose each of these within a cycle or two.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  // Strobes issued by the control unit to the address datapath each cycle.
  typedef struct packed {
    logic loadFrame;  // start of frame: restart line and element address at a base
    logic usePong;    // base select for loadFrame: 0 ping, 1 pong
    logic nextLine;   // line finished: step line start by the offset
    logic loadElem;   // capture head element and its address into the request register
  } ppdmaStrobes_t;
endpackage

// File: rtl/ppdma_ctrl.sv
module ppdma_ctrl
  import ppdma_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             frameStart,
  input  logic             lineEnd,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             reqGrant,
  output logic             reqValid,
  output logic             fifoPop,
  output ppdmaStrobes_t    strb
);
  logic bufSel;       // base for the next frame: 0 ping, 1 pong
  logic frameActive;
  logic validQ;
  logic slotFree;
  logic canLoad;

  // The request slot frees up when it is empty or being granted this cycle.
  assign slotFree = !validQ || reqGrant;
  // No element is loaded in a frameStart cycle, so the address always comes from the new frame.
  assign canLoad  = enable && frameActive && !frameStart && (fifoLevel != '0) && slotFree;

  always_comb begin
    strb.loadFrame = enable && frameStart;
    strb.usePong   = bufSel;
    strb.nextLine  = enable && frameActive && lineEnd && !frameStart;
    strb.loadElem  = canLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufSel      <= 1'b0;
      frameActive <= 1'b0;
    end else if (!enable) begin
      bufSel      <= 1'b0;
      frameActive <= 1'b0;
    end else if (frameStart) begin
      bufSel      <= ~bufSel;
      frameActive <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         validQ <= 1'b0;
    else if (canLoad)  validQ <= 1'b1;
    else if (reqGrant) validQ <= 1'b0;
  end

  assign reqValid = validQ;
  assign fifoPop  = canLoad;

  // R8: never pop an empty FIFO
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (fifoLevel != '0));

  // R6: a pending request is not withdrawn before its grant
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGrant) |=> reqValid);

  // R6: no pop while the slot is occupied and not granted
  p_no_pop_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGrant) |-> !fifoPop);

  // R7: a grant with data available and a running frame is refilled without a gap
  p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqGrant && fifoLevel != '0 && enable && frameActive && !frameStart) |=> reqValid);

  // R9: being disabled always leaves the alternation pointing at ping
  p_restart_ping_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !bufSel);

  // R3: each accepted frame start flips the buffer select
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && frameStart) |=> (bufSel != $past(bufSel)));
endmodule

// File: rtl/ppdma_datapath.sv
module ppdma_datapath
  import ppdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_W    = 5,
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 16,
  parameter int ELEM_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ppdmaStrobes_t             strb,
  input  logic [ADDR_W-ALIGN_W-1:0] pingBase,
  input  logic [ADDR_W-ALIGN_W-1:0] pongBase,
  input  logic [OFS_W-1:0]          lineOffset,
  input  logic [DATA_W-1:0]         fifoData,
  input  logic                      reqValid,
  input  logic                      reqGrant,
  output logic [ADDR_W-1:0]         reqAddr,
  output logic [DATA_W-1:0]         reqData
);
  localparam int                BASE_W    = ADDR_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] ELEM_STEP = ADDR_W'(ELEM_BYTES);

  logic [ADDR_W-1:0] lineStart;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BASE_W-1:0] selBase;
  logic [ADDR_W-1:0] frameBase;
  logic [ADDR_W-1:0] stepLine;

  assign selBase   = strb.usePong ? pongBase : pingBase;
  assign frameBase = {selBase, {ALIGN_W{1'b0}}};
  assign stepLine  = lineStart + ADDR_W'(lineOffset);

  // Frame start wins over line end; line end wins over the element step,
  // so an element loaded in a lineEnd cycle still uses the old line's address.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineStart <= '0;
      nextAddr  <= '0;
    end else if (strb.loadFrame) begin
      lineStart <= frameBase;
      nextAddr  <= frameBase;
    end else if (strb.nextLine) begin
      lineStart <= stepLine;
      nextAddr  <= stepLine;
    end else if (strb.loadElem) begin
      nextAddr  <= nextAddr + ELEM_STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.loadElem) begin
      addrQ <= nextAddr;
      dataQ <= fifoData;
    end
  end

  assign reqAddr = addrQ;
  assign reqData = dataQ;

  // R6: address and data stay put while a request waits for its grant
  p_stable_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGrant) |=> ($stable(reqAddr) && $stable(reqData)));

  // R2: a frame always starts on an aligned base
  p_aligned_base_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |=> (nextAddr[ALIGN_W-1:0] == '0) && (lineStart == nextAddr));

  // R4: a plain element load advances the next address by one element
  p_elem_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadElem && !strb.nextLine && !strb.loadFrame) |=> (nextAddr == $past(nextAddr) + ELEM_STEP));

  // R5: a line end moves both pointers to the previous line start plus the offset
  p_line_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.nextLine && !strb.loadFrame) |=>
      (lineStart == $past(lineStart) + ADDR_W'($past(lineOffset))) && (nextAddr == lineStart));
endmodule

// File: rtl/ppdma_addr_gen.sv
module ppdma_addr_gen
  import ppdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_W    = 5,
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 16,
  parameter int LVL_W      = 4,
  parameter int ELEM_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [ADDR_W-ALIGN_W-1:0] pingBase,
  input  logic [ADDR_W-ALIGN_W-1:0] pongBase,
  input  logic [OFS_W-1:0]          lineOffset,
  input  logic                      frameStart,
  input  logic                      lineEnd,
  input  logic [LVL_W-1:0]          fifoLevel,
  input  logic [DATA_W-1:0]         fifoData,
  output logic                      fifoPop,
  output logic                      reqValid,
  input  logic                      reqGrant,
  output logic [ADDR_W-1:0]         reqAddr,
  output logic [DATA_W-1:0]         reqData
);
  ppdmaStrobes_t strb;

  ppdma_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .frameStart (frameStart),
    .lineEnd    (lineEnd),
    .fifoLevel  (fifoLevel),
    .reqGrant   (reqGrant),
    .reqValid   (reqValid),
    .fifoPop    (fifoPop),
    .strb       (strb)
  );

  ppdma_datapath #(
    .ADDR_W     (ADDR_W),
    .ALIGN_W    (ALIGN_W),
    .DATA_W     (DATA_W),
    .OFS_W      (OFS_W),
    .ELEM_BYTES (ELEM_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pingBase   (pingBase),
    .pongBase   (pongBase),
    .lineOffset (lineOffset),
    .fifoData   (fifoData),
    .reqValid   (reqValid),
    .reqGrant   (reqGrant),
    .reqAddr    (reqAddr),
    .reqData    (reqData)
  );
endmodule

// File: tb/ppdma_addr_gen_tb.sv
module ppdma_addr_gen_tb;
  localparam int ADDR_W = 32;
  localparam int ALIGN_W = 5;
  localparam int DATA_W = 32;
  localparam int OFS_W = 16;
  localparam int LVL_W = 4;
  localparam int STEP = 4;
  localparam logic [DATA_W-1:0] DATA_BASE = 32'hA500_0000;
  localparam logic [ADDR_W-ALIGN_W-1:0] PING = 27'h010_0000;
  localparam logic [ADDR_W-ALIGN_W-1:0] PONG = 27'h010_0100;
  localparam logic [OFS_W-1:0] OFS = 16'h0400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic frameStart = 1'b0;
  logic lineEnd = 1'b0;
  logic reqGrant = 1'b0;
  logic fifoPop, reqValid;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [LVL_W-1:0] fifoLevel;
  logic [DATA_W-1:0] fifoData;

  int pushCount = 0;
  int popCount = 0;
  int cyc = 0;
  int txN = 0;
  logic [ADDR_W-1:0] txAddr [64];
  logic [DATA_W-1:0] txData [64];
  int txCyc [64];
  int nTests = 0;
  int nFail = 0;
  bit nextPong = 0;

  always #10 clk = ~clk;

  assign fifoLevel = LVL_W'(pushCount - popCount);
  assign fifoData  = DATA_BASE + DATA_W'(popCount);

  ppdma_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .pingBase(PING), .pongBase(PONG),
    .lineOffset(OFS), .frameStart(frameStart), .lineEnd(lineEnd),
    .fifoLevel(fifoLevel), .fifoData(fifoData), .fifoPop(fifoPop),
    .reqValid(reqValid), .reqGrant(reqGrant), .reqAddr(reqAddr), .reqData(reqData)
  );

  // FIFO model and grant monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifoPop) popCount <= popCount + 1;
    if (reqValid && reqGrant && txN < 64) begin
      txAddr[txN] <= reqAddr;
      txData[txN] <= reqData;
      txCyc[txN]  <= cyc;
      txN <= txN + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] fullBase(input bit pong);
    return {pong ? PONG : PING, 5'b0};
  endfunction

  task automatic startFrame(output logic [ADDR_W-1:0] base);
    base = fullBase(nextPong);
    nextPong = !nextPong;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "reqValid after reset", reqValid, 0);
    check("R1", "fifoPop after reset", fifoPop, 0);
  endtask

  task automatic tPingPong();
    logic [ADDR_W-1:0] b;
    enable = 1'b1; reqGrant = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 4; f++) begin
      int s = txN;
      startFrame(b);
      check("R3", "frame base select", b, fullBase(f % 2 == 1));
      pushCount += 2;
      waitCyc(6);
      check("R3", "grants per frame", txN - s, 2);
      check("R2", "first element address", txAddr[s], b);
      check("R2", "low five bits zero", txAddr[s][4:0], 0);
      check("R4", "second element address", txAddr[s+1], b + STEP);
    end
  endtask

  task automatic tLines();
    logic [ADDR_W-1:0] b;
    int s = txN;
    startFrame(b);
    pushCount += 3;
    waitCyc(6);
    lineEnd = 1'b1; @(negedge clk); lineEnd = 1'b0;
    pushCount += 3;
    waitCyc(6);
    check("R5", "grants in two lines", txN - s, 6);
    for (int i = 0; i < 3; i++) begin
      check("R4", "line0 element", txAddr[s+i], b + ADDR_W'(STEP*i));
      check("R5", "line1 element", txAddr[s+3+i], b + ADDR_W'(OFS) + ADDR_W'(STEP*i));
    end
  endtask

  task automatic tStall();
    logic [ADDR_W-1:0] b;
    logic [ADDR_W-1:0] a0;
    logic [DATA_W-1:0] d0;
    int s = txN;
    int p;
    reqGrant = 1'b0;
    startFrame(b);
    p = popCount;
    pushCount += 2;
    waitCyc(4);
    check("R6", "valid while stalled", reqValid, 1);
    check("R6", "stalled address", reqAddr, b);
    check("R6", "one pop while stalled", popCount - p, 1);
    a0 = reqAddr; d0 = reqData;
    waitCyc(3);
    check("R6", "address held", reqAddr, a0);
    check("R6", "data held", reqData, d0);
    check("R6", "still one pop", popCount - p, 1);
    reqGrant = 1'b1;
    waitCyc(4);
    check("R6", "grants after release", txN - s, 2);
    check("R4", "second after stall", txAddr[s+1], b + STEP);
  endtask

  task automatic tBackToBack();
    logic [ADDR_W-1:0] b;
    int s = txN;
    startFrame(b);
    pushCount += 6;
    waitCyc(10);
    check("R7", "grant count", txN - s, 6);
    for (int i = 1; i < 6; i++) begin
      check("R7", "no idle between grants", txCyc[s+i] - txCyc[s+i-1], 1);
      check("R7", "data in FIFO order", txData[s+i] - txData[s+i-1], 1);
      check("R4", "consecutive address", txAddr[s+i], b + ADDR_W'(STEP*i));
    end
  endtask

  task automatic tEmptyAndReenable();
    logic [ADDR_W-1:0] b;
    int s = txN;
    int p = popCount;
    // frame active, FIFO empty
    waitCyc(5);
    check("R8", "no request when empty", reqValid, 0);
    check("R8", "no pop when empty", popCount - p, 0);
    // disabled with data waiting
    enable = 1'b0; nextPong = 0;
    pushCount += 2;
    waitCyc(5);
    check("R8", "no pop while disabled", popCount - p, 0);
    check("R8", "no grant while disabled", txN - s, 0);
    enable = 1'b1;
    waitCyc(3);
    check("R8", "no pop without a frame", popCount - p, 0);
    startFrame(b);
    waitCyc(5);
    check("R9", "grants after re-enable", txN - s, 2);
    check("R9", "restart at ping", txAddr[s], fullBase(1'b0));
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    tReset();
    tPingPong();
    tLines();      // parity after four frames: ping
    tStall();      // pong
    tBackToBack(); // ping; the next frame would use pong
    tEmptyAndReenable();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule